// File: doc/BRIEF.md
# Shadowed Register Access Buffer

This block sits between a byte-oriented serial bus front end and a bank of live timekeeping registers. The host reads from a secondary copy of the register bank. That copy is taken from the live values only at defined protocol moments. A multi-byte time value read in one burst is therefore always self-consistent, even when the timekeeper advances its counters in the middle of the burst.

Host writes are staged when the byte arrives. They reach the timekeeper only when the acknowledge strobe for that byte comes, as a one-cycle commit pulse with an address and a data byte. When a commit targets the seconds register, the block also raises a pulse that tells the timekeeper to restart its sub-second divider.

An auto-incrementing register pointer selects the byte that is read or written. The first data byte after a write-direction device address loads this pointer. The bus front end supplies each bus event as a single-cycle strobe.

Top module: `shadow_regbuf`

## Requirements
- R1: A start strobe copies every live register into the read copy; the copied values appear on `rd_data` from the next clock edge.
- R2: A stop strobe performs the same full copy of the live registers into the read copy.
- R3: When the pointer steps from the last register (NREG-1) back to 0, the read copy is refreshed from the live registers on that same edge.
- R4: Outside the three capture events, a change of `live_regs` has no effect on `rd_data`; a burst keeps returning the values captured at its start.
- R5: After a write-direction address (`bus_devaddr` with `bus_dev_rd`=0), the next written byte is a pointer byte. On its acknowledge it loads the pointer, and no commit pulse is produced. A pointer byte of NREG or more loads 0.
- R6: A written data byte produces no commit until its acknowledge. On the edge that samples `bus_ack`, `commit_we` rises for exactly one cycle, with `commit_addr` set to the pointer and `commit_data` set to the byte.
- R7: `presc_rst` pulses together with `commit_we` exactly when `commit_addr` equals SEC_ADDR (default 0).
- R8: The pointer advances by one after each read byte and after each committed data byte, and steps from NREG-1 to 0.
- R9: An acknowledge with no staged byte behind it (for example, the address acknowledge) causes no commit and leaves the pointer unchanged.
- R10: After reset, the pointer is 0, the read copy is all zero, and `commit_we` and `presc_rst` are low.
- R11: A read-direction address keeps the pointer, so a read burst continues from where the last access left it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_start | input | 1 | Start condition strobe |
| bus_stop | input | 1 | Stop condition strobe |
| bus_devaddr | input | 1 | Device address matched strobe |
| bus_dev_rd | input | 1 | Direction sampled with `bus_devaddr`: 1 = read |
| bus_wr_byte | input | 1 | Host byte received strobe |
| bus_wdata | input | 8 | Byte received from host |
| bus_ack | input | 1 | Acknowledge strobe for a received byte |
| bus_rd_byte | input | 1 | Host has taken the current read byte |
| live_regs | input | 8*NREG | Live register bank, register i in bits [8i+7:8i] |
| rd_data | output | 8 | Read copy byte at the pointer |
| commit_we | output | 1 | One-cycle write pulse toward the timekeeper |
| commit_addr | output | $clog2(NREG) | Register index of the commit |
| commit_data | output | 8 | Byte to write |
| presc_rst | output | 1 | Divider restart pulse on a seconds commit |

## Verification
A capture, a pointer load or a pointer step takes effect on the edge that samples the strobe. `rd_data` follows that edge without further delay because it is a mux on the registered pointer. `commit_we`, `commit_addr`, `commit_data` and `presc_rst` are registered on the edge that samples `bus_ack`, and they stay valid only until the next edge. The bench asserts each strobe on a falling edge and drops it on the next falling edge. It compares outputs at that second falling edge, which is half a cycle after the edge that acted on the strobe. It takes one more falling edge to confirm that the commit pulse is gone.

// File: rtl/regbuf_pkg.sv
package regbuf_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PTR  = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  function automatic logic [31:0] ptr_step(input logic [31:0] p, input logic [31:0] n);
    return (p >= n - 32'd1) ? 32'd0 : p + 32'd1;
  endfunction

  function automatic logic [31:0] ptr_clamp(input logic [31:0] v, input logic [31:0] n);
    return (v < n) ? v : 32'd0;
  endfunction

  function automatic logic ptr_at_last(input logic [31:0] p, input logic [31:0] n);
    return p == n - 32'd1;
  endfunction

endpackage

// File: rtl/regbuf_pointer.sv
module regbuf_pointer
  import regbuf_pkg::*;
#(
  parameter int NREG = 7,
  parameter int PW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] load_val,
  input  logic          inc,
  output logic [PW-1:0] ptr,
  output logic          wrap_evt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_val;
    else if (inc)  ptr <= PW'(ptr_step(32'(ptr), 32'(NREG)));
  end

  assign wrap_evt = inc && !load && ptr_at_last(32'(ptr), 32'(NREG));

  // R8
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ptr) < 32'(NREG));

  // R8
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> ptr == '0);

  // R9
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !inc) |=> $stable(ptr));

endmodule

// File: rtl/regbuf_stage.sv
module regbuf_stage
  import regbuf_pkg::*;
#(
  parameter int NREG     = 7,
  parameter int SEC_ADDR = 0,
  parameter int PW       = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_start,
  input  logic          bus_stop,
  input  logic          bus_devaddr,
  input  logic          bus_dev_rd,
  input  logic          bus_wr_byte,
  input  logic [7:0]    bus_wdata,
  input  logic          bus_ack,
  input  logic [PW-1:0] ptr,
  output logic          ptr_load,
  output logic [PW-1:0] ptr_load_val,
  output logic          wr_inc,
  output logic          commit_we,
  output logic [PW-1:0] commit_addr,
  output logic [7:0]    commit_data,
  output logic          presc_rst
);

  phase_e     phase;
  logic       stg_vld;
  logic       stg_is_ptr;
  logic [7:0] stg_data;
  logic       accept;
  logic       frame_edge;
  logic       sec_hit;

  assign frame_edge = bus_start || bus_stop;
  assign accept     = bus_wr_byte && (phase != PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 phase <= PH_IDLE;
    else if (frame_edge)        phase <= PH_IDLE;
    else if (bus_devaddr)       phase <= bus_dev_rd ? PH_DATA : PH_PTR;
    else if (ptr_load)          phase <= PH_DATA;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_vld    <= 1'b0;
      stg_is_ptr <= 1'b0;
      stg_data   <= '0;
    end else if (frame_edge) begin
      stg_vld    <= 1'b0;
    end else if (accept) begin
      stg_vld    <= 1'b1;
      stg_is_ptr <= (phase == PH_PTR);
      stg_data   <= bus_wdata;
    end else if (bus_ack) begin
      stg_vld    <= 1'b0;
    end
  end

  assign ptr_load     = bus_ack && stg_vld && stg_is_ptr;
  assign wr_inc       = bus_ack && stg_vld && !stg_is_ptr;
  assign ptr_load_val = PW'(ptr_clamp(32'(stg_data), 32'(NREG)));
  assign sec_hit      = (32'(ptr) == 32'(SEC_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit_we   <= 1'b0;
      commit_addr <= '0;
      commit_data <= '0;
      presc_rst   <= 1'b0;
    end else begin
      commit_we <= wr_inc;
      presc_rst <= wr_inc && sec_hit;
      if (wr_inc) begin
        commit_addr <= ptr;
        commit_data <= stg_data;
      end
    end
  end

  // R6
  commit_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_we |-> $past(bus_ack));

  // R5
  ptr_byte_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load |=> !commit_we);

  // R7
  presc_with_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    presc_rst |-> (commit_we && 32'(commit_addr) == 32'(SEC_ADDR)));

  // R9
  stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ack && !stg_vld) |=> !commit_we);

endmodule

// File: rtl/regbuf_shadow.sv
module regbuf_shadow #(
  parameter int NREG = 7,
  parameter int PW   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic [8*NREG-1:0] live_regs,
  input  logic [PW-1:0]     ptr,
  output logic [7:0]        rd_data
);

  logic [7:0] sh [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   sh[g] <= '0;
      else if (cap) sh[g] <= live_regs[g*8 +: 8];
    end

    // R4
    shadow_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cap |=> $stable(sh[g]));

    // R1 R2 R3
    shadow_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap |=> sh[g] == $past(live_regs[g*8 +: 8]));
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++) begin
      if (32'(ptr) == i) rd_data = sh[i];
    end
  end

endmodule

// File: rtl/shadow_regbuf.sv
module shadow_regbuf #(
  parameter int NREG     = 7,
  parameter int SEC_ADDR = 0,
  localparam int PW      = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              bus_devaddr,
  input  logic              bus_dev_rd,
  input  logic              bus_wr_byte,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_ack,
  input  logic              bus_rd_byte,
  input  logic [8*NREG-1:0] live_regs,
  output logic [7:0]        rd_data,
  output logic              commit_we,
  output logic [PW-1:0]     commit_addr,
  output logic [7:0]        commit_data,
  output logic              presc_rst
);

  logic [PW-1:0] ptr;
  logic [PW-1:0] ptr_load_val;
  logic          ptr_load;
  logic          wr_inc;
  logic          ptr_inc;
  logic          wrap_evt;
  logic          cap_evt;

  assign ptr_inc = wr_inc || bus_rd_byte;
  assign cap_evt = bus_start || bus_stop || wrap_evt;

  regbuf_stage #(.NREG(NREG), .SEC_ADDR(SEC_ADDR), .PW(PW)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .bus_start(bus_start), .bus_stop(bus_stop),
    .bus_devaddr(bus_devaddr), .bus_dev_rd(bus_dev_rd),
    .bus_wr_byte(bus_wr_byte), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .ptr(ptr), .ptr_load(ptr_load), .ptr_load_val(ptr_load_val), .wr_inc(wr_inc),
    .commit_we(commit_we), .commit_addr(commit_addr), .commit_data(commit_data),
    .presc_rst(presc_rst)
  );

  regbuf_pointer #(.NREG(NREG), .PW(PW)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .load(ptr_load), .load_val(ptr_load_val), .inc(ptr_inc),
    .ptr(ptr), .wrap_evt(wrap_evt)
  );

  regbuf_shadow #(.NREG(NREG), .PW(PW)) u_shadow (
    .clk(clk), .rst_n(rst_n),
    .cap(cap_evt), .live_regs(live_regs), .ptr(ptr), .rd_data(rd_data)
  );

  // R6
  commit_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_we && !$past(bus_ack, 1) ) |-> 1'b0 );

  // R1
  start_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> rd_data == $past(live_regs[8*32'(ptr) +: 8]));

endmodule

// File: tb/test_shadow_regbuf.sv
`timescale 1ns/1ps
module test_shadow_regbuf;
  localparam int NREG = 7;
  localparam int PW   = $clog2(NREG);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_start = 0, bus_stop = 0, bus_devaddr = 0, bus_dev_rd = 0;
  logic bus_wr_byte = 0, bus_ack = 0, bus_rd_byte = 0;
  logic [7:0] bus_wdata = '0;
  logic [8*NREG-1:0] live_regs = '0;
  logic [7:0] rd_data;
  logic commit_we, presc_rst;
  logic [PW-1:0] commit_addr;
  logic [7:0] commit_data;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_sh [NREG];
  int exp_ptr = 0;

  always #2 clk = ~clk;

  shadow_regbuf #(.NREG(NREG)) i_shadow_regbuf (
    .clk(clk), .rst_n(rst_n),
    .bus_start(bus_start), .bus_stop(bus_stop),
    .bus_devaddr(bus_devaddr), .bus_dev_rd(bus_dev_rd),
    .bus_wr_byte(bus_wr_byte), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rd_byte(bus_rd_byte), .live_regs(live_regs),
    .rd_data(rd_data), .commit_we(commit_we), .commit_addr(commit_addr),
    .commit_data(commit_data), .presc_rst(presc_rst)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic capture_model();
    for (int i = 0; i < NREG; i++) exp_sh[i] = live_regs[i*8 +: 8];
  endtask

  task automatic set_live(input logic [7:0] base);
    for (int i = 0; i < NREG; i++) live_regs[i*8 +: 8] = base + 8'(i);
  endtask

  task automatic do_start();
    @(negedge clk); bus_start = 1;
    @(negedge clk); bus_start = 0; capture_model();
  endtask

  task automatic do_stop();
    @(negedge clk); bus_stop = 1;
    @(negedge clk); bus_stop = 0; capture_model();
  endtask

  task automatic do_dev(input logic rd);
    @(negedge clk); bus_devaddr = 1; bus_dev_rd = rd;
    @(negedge clk); bus_devaddr = 0;
  endtask

  task automatic do_wr(input logic [7:0] v);
    @(negedge clk); bus_wr_byte = 1; bus_wdata = v;
    @(negedge clk); bus_wr_byte = 0;
  endtask

  task automatic do_ack();
    @(negedge clk); bus_ack = 1;
    @(negedge clk); bus_ack = 0;
  endtask

  task automatic do_rd();
    logic wrap;
    wrap = (exp_ptr == NREG - 1);
    @(negedge clk); bus_rd_byte = 1;
    @(negedge clk); bus_rd_byte = 0;
    exp_ptr = wrap ? 0 : exp_ptr + 1;
    if (wrap) capture_model();
  endtask

  task automatic check_rd(input string req);
    chk(req, "rd_data", 32'(rd_data), 32'(exp_sh[exp_ptr]));
  endtask

  task automatic t_reset();
    chk("R10", "rd_data", 32'(rd_data), 32'h0);
    chk("R10", "commit_we", 32'(commit_we), 32'h0);
    chk("R10", "presc_rst", 32'(presc_rst), 32'h0);
  endtask

  task automatic t_start_capture();
    set_live(8'h10);
    do_start();
    chk("R1", "rd_data after start", 32'(rd_data), 32'h10);
    do_dev(1'b1);
    check_rd("R11");
  endtask

  task automatic t_frozen_burst();
    set_live(8'h20);
    for (int k = 0; k < 3; k++) begin
      do_rd();
      check_rd("R4");
    end
    chk("R4", "rd_data old burst", 32'(rd_data), 32'h13);
  endtask

  task automatic t_read_wrap();
    while (exp_ptr != 0) begin
      do_rd();
      check_rd("R8");
    end
    chk("R3", "rd_data after wrap", 32'(rd_data), 32'h20);
  endtask

  task automatic t_stop_capture();
    set_live(8'h30);
    do_rd();
    check_rd("R4");
    do_stop();
    chk("R2", "rd_data after stop", 32'(rd_data), 32'h31);
  endtask

  task automatic t_ptr_load();
    do_start();
    do_dev(1'b0);
    do_wr(8'd3);
    chk("R5", "commit_we before ack", 32'(commit_we), 32'h0);
    do_ack();
    chk("R5", "commit_we on ptr ack", 32'(commit_we), 32'h0);
    exp_ptr = 3;
    do_stop();
    chk("R5", "rd_data at loaded ptr", 32'(rd_data), 32'h33);
  endtask

  task automatic t_commit();
    do_start();
    do_dev(1'b0);
    do_wr(8'd2); do_ack(); exp_ptr = 2;
    do_wr(8'h45);
    chk("R6", "commit_we before ack", 32'(commit_we), 32'h0);
    do_ack();
    chk("R6", "commit_we", 32'(commit_we), 32'h1);
    chk("R6", "commit_addr", 32'(commit_addr), 32'h2);
    chk("R6", "commit_data", 32'(commit_data), 32'h45);
    chk("R7", "presc_rst off", 32'(presc_rst), 32'h0);
    @(negedge clk);
    chk("R6", "commit_we one cycle", 32'(commit_we), 32'h0);
    do_wr(8'h12); do_ack();
    chk("R8", "commit_addr step", 32'(commit_addr), 32'h3);
    exp_ptr = 4;
    do_stop();
  endtask

  task automatic t_seconds();
    do_start();
    do_dev(1'b0);
    do_wr(8'd0); do_ack();
    do_wr(8'h59); do_ack();
    chk("R7", "presc_rst", 32'(presc_rst), 32'h1);
    chk("R7", "commit_addr", 32'(commit_addr), 32'h0);
    @(negedge clk);
    chk("R7", "presc_rst one cycle", 32'(presc_rst), 32'h0);
    exp_ptr = 1;
    do_stop();
  endtask

  task automatic t_range();
    do_start();
    do_dev(1'b0);
    do_wr(8'd200); do_ack();
    do_wr(8'h77); do_ack();
    chk("R5", "out of range ptr", 32'(commit_addr), 32'h0);
    chk("R5", "commit_data", 32'(commit_data), 32'h77);
    exp_ptr = 1;
    do_stop();
  endtask

  task automatic t_stray_ack();
    do_start();
    do_dev(1'b0);
    do_ack();
    chk("R9", "commit_we addr ack", 32'(commit_we), 32'h0);
    do_wr(8'd5); do_ack();
    do_ack();
    chk("R9", "commit_we stray ack", 32'(commit_we), 32'h0);
    exp_ptr = 5;
    do_stop();
    chk("R9", "ptr unchanged", 32'(rd_data), 32'h35);
  endtask

  task automatic t_write_wrap();
    do_start();
    do_dev(1'b0);
    do_wr(8'd6); do_ack();
    do_wr(8'hA1); do_ack();
    chk("R8", "commit_addr last", 32'(commit_addr), 32'h6);
    do_wr(8'hA2); do_ack();
    chk("R8", "commit_addr wrapped", 32'(commit_addr), 32'h0);
    chk("R7", "presc_rst on wrap", 32'(presc_rst), 32'h1);
    exp_ptr = 1;
    do_stop();
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) exp_sh[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_start_capture();
    t_frozen_burst();
    t_read_wrap();
    t_stop_capture();
    t_ptr_load();
    t_commit();
    t_seconds();
    t_range();
    t_stray_ack();
    t_write_wrap();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule